// File: doc/BRIEF.md
# Mailbox Event Status and Interrupt Gate

This block sits beside the message core of a sixteen-mailbox CAN controller. It holds the per-mailbox status words and the four interrupt request flags that relate to mailbox traffic. The core sends one strobe vector per event kind: data frame stored, remote frame stored, overrun or overwrite, transmission finished, and transmission aborted. Each strobe carries one bit per mailbox. Software sees all of this through a small register port. It sets transmit requests, reads and acknowledges status, and programs a per-mailbox interrupt mask.

The mask gates only the interrupt flags. A masked mailbox still records every event in its status bits. Transmit-pending and transmit-cancel bits are still dropped when a transfer ends. The single interrupt line goes high whenever any stored flag is set.

Register map: address 0 is the mask, 1 receive-pending, 2 remote-pending, 3 unread-message, 4 transmit-pending, 5 transmit-cancel, 6 transmit-acknowledge, 7 abort-acknowledge, 8 interrupt flags. In every status register and in the mask, bit n belongs to mailbox n.

Top module: `mbox_event_irq`

## Requirements
- R1: The mask register at address 0 is read/write and resets to 0xFFFF. A 1 in bit n masks mailbox n and a 0 unmasks it.
- R2: A data-frame strobe for mailbox n sets bit n of receive-pending (address 1) whether or not the mailbox is masked. It sets interrupt flag bit 1 only if mailbox n is unmasked.
- R3: A remote-frame strobe for mailbox n sets bit n of remote-pending (address 2) in every case. It sets interrupt flag bit 2 only if mailbox n is unmasked.
- R4: An overrun strobe for mailbox n sets bit n of unread-message (address 3) in every case. It sets interrupt flag bit 9 only if mailbox n is unmasked.
- R5: A transmit-done strobe for mailbox n clears bit n of transmit-pending (address 4) and transmit-cancel (address 5), and sets bit n of transmit-acknowledge (address 6), whether or not the mailbox is masked. It sets interrupt flag bit 8 only if mailbox n is unmasked.
- R6: An abort strobe for mailbox n clears bit n of transmit-pending and transmit-cancel and sets bit n of abort-acknowledge (address 7) in every case. It sets interrupt flag bit 8 only if mailbox n is unmasked.
- R7: Writing 1 to a bit of addresses 1, 2, 3, 6 or 7 clears that bit, and writing 0 leaves it alone. If a hardware set arrives in the same cycle as the clear, the bit stays set.
- R8: Writing 1 to a bit of address 4 or 5 sets that bit, and writing 0 has no effect. If a done or abort strobe arrives in the same cycle as the software set, the bit ends cleared.
- R9: The interrupt flags at address 8 hold only bits 1, 2, 8 and 9; every other bit reads 0. Writing 1 clears a flag. A new gated event in the same cycle as the clear keeps the flag set. A flag is set when at least one unmasked mailbox reports a matching event, and several mailboxes at once set it just the same.
- R10: The interrupt output is high exactly when any interrupt flag is set. Masking a mailbox later does not clear a flag that is already set.
- R11: After reset every status register and every interrupt flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for reads and writes |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| evRxData | input | 16 | Data frame stored, one bit per mailbox |
| evRxRemote | input | 16 | Remote frame stored, one bit per mailbox |
| evOverrun | input | 16 | Overrun or overwrite, one bit per mailbox |
| evTxDone | input | 16 | Transmission finished, one bit per mailbox |
| evTxAbort | input | 16 | Transmission aborted, one bit per mailbox |
| maskOut | output | 16 | Current mask |
| rxPendOut | output | 16 | Receive-pending status |
| rfPendOut | output | 16 | Remote-pending status |
| unreadOut | output | 16 | Unread-message status |
| txPendOut | output | 16 | Transmit-pending bits |
| txCancelOut | output | 16 | Transmit-cancel bits |
| txAckOut | output | 16 | Transmit-acknowledge status |
| abortAckOut | output | 16 | Abort-acknowledge status |
| irqFlags | output | 16 | Interrupt flags (bits 1, 2, 8, 9 used) |
| irq | output | 1 | Interrupt request line |

## Verification
The assertions assume that the core never reports a transmit-done and an abort for the same mailbox in the same cycle. They also assume that event strobes are single-cycle pulses sampled on the rising clock edge. The stimulus meets both conditions: it raises one event kind at a time, except in the directed same-cycle cases, and those pair an event only with a register write. Every input changes on the falling edge. The main sweep walks each mailbox through each event kind under two alternating mask patterns, so every mailbox is seen both masked and unmasked.

// File: rtl/mbox_evt_pkg.sv
package mbox_evt_pkg;

  localparam logic [3:0] ADR_MASK   = 4'd0;
  localparam logic [3:0] ADR_RXPEND = 4'd1;
  localparam logic [3:0] ADR_RFPEND = 4'd2;
  localparam logic [3:0] ADR_UNREAD = 4'd3;
  localparam logic [3:0] ADR_TXPEND = 4'd4;
  localparam logic [3:0] ADR_TXCAN  = 4'd5;
  localparam logic [3:0] ADR_TXACK  = 4'd6;
  localparam logic [3:0] ADR_ABACK  = 4'd7;
  localparam logic [3:0] ADR_IRQ    = 4'd8;

  localparam int IRQ_KINDS = 4;

  // flag slot k -> bit position in the interrupt flag word
  function automatic int irqPos(input int k);
    case (k)
      0:       irqPos = 1;  // data frame received
      1:       irqPos = 2;  // remote frame received
      2:       irqPos = 8;  // mailbox empty (done or abort)
      default: irqPos = 9;  // overrun / overwrite
    endcase
  endfunction

  typedef struct packed {
    logic maskWr;
    logic rxClr;
    logic rfClr;
    logic unrdClr;
    logic txpSet;
    logic txcSet;
    logic ackClr;
    logic abkClr;
    logic irqClr;
    logic [IRQ_KINDS-1:0] irqHit;
  } evtStrobe_t;

endpackage

// File: rtl/mbox_evt_ctrl.sv
module mbox_evt_ctrl
  import mbox_evt_pkg::*;
#(
  parameter int NUM_MBOX = 16
) (
  input  logic                regWrEn,
  input  logic [3:0]          regAddr,
  input  logic [NUM_MBOX-1:0] maskQ,
  input  logic [NUM_MBOX-1:0] evRxData,
  input  logic [NUM_MBOX-1:0] evRxRemote,
  input  logic [NUM_MBOX-1:0] evOverrun,
  input  logic [NUM_MBOX-1:0] evTxDone,
  input  logic [NUM_MBOX-1:0] evTxAbort,
  output evtStrobe_t          stb
);

  logic [NUM_MBOX-1:0] openMask;

  always_comb begin
    openMask      = ~maskQ;
    stb.maskWr    = regWrEn && (regAddr == ADR_MASK);
    stb.rxClr     = regWrEn && (regAddr == ADR_RXPEND);
    stb.rfClr     = regWrEn && (regAddr == ADR_RFPEND);
    stb.unrdClr   = regWrEn && (regAddr == ADR_UNREAD);
    stb.txpSet    = regWrEn && (regAddr == ADR_TXPEND);
    stb.txcSet    = regWrEn && (regAddr == ADR_TXCAN);
    stb.ackClr    = regWrEn && (regAddr == ADR_TXACK);
    stb.abkClr    = regWrEn && (regAddr == ADR_ABACK);
    stb.irqClr    = regWrEn && (regAddr == ADR_IRQ);
    stb.irqHit[0] = |(evRxData & openMask);
    stb.irqHit[1] = |(evRxRemote & openMask);
    stb.irqHit[2] = |((evTxDone | evTxAbort) & openMask);
    stb.irqHit[3] = |(evOverrun & openMask);
  end

endmodule

// File: rtl/mbox_evt_dp.sv
module mbox_evt_dp
  import mbox_evt_pkg::*;
#(
  parameter int NUM_MBOX = 16,
  parameter int REG_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  evtStrobe_t          stb,
  input  logic [3:0]          regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [NUM_MBOX-1:0] evRxData,
  input  logic [NUM_MBOX-1:0] evRxRemote,
  input  logic [NUM_MBOX-1:0] evOverrun,
  input  logic [NUM_MBOX-1:0] evTxDone,
  input  logic [NUM_MBOX-1:0] evTxAbort,
  output logic [NUM_MBOX-1:0] maskQ,
  output logic [NUM_MBOX-1:0] rxPendQ,
  output logic [NUM_MBOX-1:0] rfPendQ,
  output logic [NUM_MBOX-1:0] unreadQ,
  output logic [NUM_MBOX-1:0] txPendQ,
  output logic [NUM_MBOX-1:0] txCanQ,
  output logic [NUM_MBOX-1:0] txAckQ,
  output logic [NUM_MBOX-1:0] abAckQ,
  output logic [REG_W-1:0]    irqWord,
  output logic [REG_W-1:0]    rdData
);

  logic [NUM_MBOX-1:0] wrBits;
  logic [IRQ_KINDS-1:0] irqQ;

  assign wrBits = regWrData[NUM_MBOX-1:0];

  // per-mailbox status slice
  for (genvar i = 0; i < NUM_MBOX; i++) begin : gMbox
    logic txEnd;
    assign txEnd = evTxDone[i] | evTxAbort[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[i]   <= 1'b1;
        rxPendQ[i] <= 1'b0;
        rfPendQ[i] <= 1'b0;
        unreadQ[i] <= 1'b0;
        txPendQ[i] <= 1'b0;
        txCanQ[i]  <= 1'b0;
        txAckQ[i]  <= 1'b0;
        abAckQ[i]  <= 1'b0;
      end else begin
        if (stb.maskWr) maskQ[i] <= wrBits[i];
        // hardware set beats software clear
        rxPendQ[i] <= evRxData[i]   | (rxPendQ[i] & ~(stb.rxClr   & wrBits[i]));
        rfPendQ[i] <= evRxRemote[i] | (rfPendQ[i] & ~(stb.rfClr   & wrBits[i]));
        unreadQ[i] <= evOverrun[i]  | (unreadQ[i] & ~(stb.unrdClr & wrBits[i]));
        txAckQ[i]  <= evTxDone[i]   | (txAckQ[i]  & ~(stb.ackClr  & wrBits[i]));
        abAckQ[i]  <= evTxAbort[i]  | (abAckQ[i]  & ~(stb.abkClr  & wrBits[i]));
        // hardware completion beats software request
        if (txEnd)                          txPendQ[i] <= 1'b0;
        else if (stb.txpSet && wrBits[i])   txPendQ[i] <= 1'b1;
        if (txEnd)                          txCanQ[i]  <= 1'b0;
        else if (stb.txcSet && wrBits[i])   txCanQ[i]  <= 1'b1;
      end
    end
  end

  // interrupt flag slots
  for (genvar k = 0; k < IRQ_KINDS; k++) begin : gIrq
    localparam int POS = irqPos(k);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqQ[k] <= 1'b0;
      else       irqQ[k] <= stb.irqHit[k] | (irqQ[k] & ~(stb.irqClr & regWrData[POS]));
    end
  end

  always_comb begin
    irqWord = '0;
    for (int k = 0; k < IRQ_KINDS; k++) irqWord[irqPos(k)] = irqQ[k];
  end

  always_comb begin
    case (regAddr)
      ADR_MASK:   rdData = REG_W'(maskQ);
      ADR_RXPEND: rdData = REG_W'(rxPendQ);
      ADR_RFPEND: rdData = REG_W'(rfPendQ);
      ADR_UNREAD: rdData = REG_W'(unreadQ);
      ADR_TXPEND: rdData = REG_W'(txPendQ);
      ADR_TXCAN:  rdData = REG_W'(txCanQ);
      ADR_TXACK:  rdData = REG_W'(txAckQ);
      ADR_ABACK:  rdData = REG_W'(abAckQ);
      ADR_IRQ:    rdData = irqWord;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/mbox_event_irq.sv
module mbox_event_irq
  import mbox_evt_pkg::*;
#(
  parameter int NUM_MBOX = 16,
  parameter int REG_W    = (NUM_MBOX > 16) ? NUM_MBOX : 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [3:0]          regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [NUM_MBOX-1:0] evRxData,
  input  logic [NUM_MBOX-1:0] evRxRemote,
  input  logic [NUM_MBOX-1:0] evOverrun,
  input  logic [NUM_MBOX-1:0] evTxDone,
  input  logic [NUM_MBOX-1:0] evTxAbort,
  output logic [NUM_MBOX-1:0] maskOut,
  output logic [NUM_MBOX-1:0] rxPendOut,
  output logic [NUM_MBOX-1:0] rfPendOut,
  output logic [NUM_MBOX-1:0] unreadOut,
  output logic [NUM_MBOX-1:0] txPendOut,
  output logic [NUM_MBOX-1:0] txCancelOut,
  output logic [NUM_MBOX-1:0] txAckOut,
  output logic [NUM_MBOX-1:0] abortAckOut,
  output logic [REG_W-1:0]    irqFlags,
  output logic                irq
);

  evtStrobe_t stb;

  mbox_evt_ctrl #(.NUM_MBOX(NUM_MBOX)) uCtrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .maskQ      (maskOut),
    .evRxData   (evRxData),
    .evRxRemote (evRxRemote),
    .evOverrun  (evOverrun),
    .evTxDone   (evTxDone),
    .evTxAbort  (evTxAbort),
    .stb        (stb)
  );

  mbox_evt_dp #(.NUM_MBOX(NUM_MBOX), .REG_W(REG_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .evRxData   (evRxData),
    .evRxRemote (evRxRemote),
    .evOverrun  (evOverrun),
    .evTxDone   (evTxDone),
    .evTxAbort  (evTxAbort),
    .maskQ      (maskOut),
    .rxPendQ    (rxPendOut),
    .rfPendQ    (rfPendOut),
    .unreadQ    (unreadOut),
    .txPendQ    (txPendOut),
    .txCanQ     (txCancelOut),
    .txAckQ     (txAckOut),
    .abAckQ     (abortAckOut),
    .irqWord    (irqFlags),
    .rdData     (regRdData)
  );

  assign irq = |irqFlags;

endmodule

// File: rtl/mbox_evt_chk.sv
module mbox_evt_chk #(
  parameter int NUM_MBOX = 16,
  parameter int REG_W    = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [3:0]          regAddr,
  input logic [REG_W-1:0]    regWrData,
  input logic [NUM_MBOX-1:0] evRxData,
  input logic [NUM_MBOX-1:0] evOverrun,
  input logic [NUM_MBOX-1:0] evTxDone,
  input logic [NUM_MBOX-1:0] evTxAbort,
  input logic [NUM_MBOX-1:0] maskOut,
  input logic [NUM_MBOX-1:0] rxPendOut,
  input logic [NUM_MBOX-1:0] txPendOut,
  input logic [NUM_MBOX-1:0] txAckOut,
  input logic [NUM_MBOX-1:0] abortAckOut,
  input logic [REG_W-1:0]    irqFlags,
  input logic                irq
);

  logic [NUM_MBOX-1:0] txpWrBits;
  logic                irqClrBit8;

  assign txpWrBits  = (regWrEn && regAddr == 4'd4) ? regWrData[NUM_MBOX-1:0] : '0;
  assign irqClrBit8 = regWrEn && (regAddr == 4'd8) && regWrData[8];

  a_r2_rx_status: assert property (@(posedge clk) disable iff (!rstN)
    (|evRxData) |=> ((rxPendOut & $past(evRxData)) == $past(evRxData)));

  a_r2_rx_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[1]) |-> $past(|(evRxData & ~maskOut)));

  a_r4_ovr_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[9]) |-> $past(|(evOverrun & ~maskOut)));

  a_r5_done_status: assert property (@(posedge clk) disable iff (!rstN)
    (|evTxDone) |=> (((txPendOut & $past(evTxDone)) == '0) &&
                     ((txAckOut & $past(evTxDone)) == $past(evTxDone))));

  a_r6_abort_status: assert property (@(posedge clk) disable iff (!rstN)
    (|evTxAbort) |=> (((txPendOut & $past(evTxAbort)) == '0) &&
                      ((abortAckOut & $past(evTxAbort)) == $past(evTxAbort))));

  a_r8_txpend_only_sw: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((txPendOut & ~$past(txPendOut) & ~$past(txpWrBits)) == '0));

  a_r10_no_retro_clear: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlags[8] && !irqClrBit8) |=> irqFlags[8]);

  a_r10_line_follows: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (irqFlags[1] || irqFlags[2] || irqFlags[8] || irqFlags[9]));

endmodule

bind mbox_event_irq mbox_evt_chk #(.NUM_MBOX(NUM_MBOX), .REG_W(REG_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .evRxData    (evRxData),
  .evOverrun   (evOverrun),
  .evTxDone    (evTxDone),
  .evTxAbort   (evTxAbort),
  .maskOut     (maskOut),
  .rxPendOut   (rxPendOut),
  .txPendOut   (txPendOut),
  .txAckOut    (txAckOut),
  .abortAckOut (abortAckOut),
  .irqFlags    (irqFlags),
  .irq         (irq)
);

// File: tb/tb_mbox_event_irq.sv
module tb_mbox_event_irq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [15:0] evRxData = '0, evRxRemote = '0, evOverrun = '0, evTxDone = '0, evTxAbort = '0;
  logic [15:0] maskOut, rxPendOut, rfPendOut, unreadOut, txPendOut, txCancelOut;
  logic [15:0] txAckOut, abortAckOut, irqFlags;
  logic        irq;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_event_irq dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evRxData(evRxData), .evRxRemote(evRxRemote), .evOverrun(evOverrun),
    .evTxDone(evTxDone), .evTxAbort(evTxAbort),
    .maskOut(maskOut), .rxPendOut(rxPendOut), .rfPendOut(rfPendOut),
    .unreadOut(unreadOut), .txPendOut(txPendOut), .txCancelOut(txCancelOut),
    .txAckOut(txAckOut), .abortAckOut(abortAckOut), .irqFlags(irqFlags), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // kind: 0 data, 1 remote, 2 overrun, 3 done, 4 abort
  task automatic setEv(input int kind, input logic [15:0] v);
    case (kind)
      0: evRxData = v;
      1: evRxRemote = v;
      2: evOverrun = v;
      3: evTxDone = v;
      default: evTxAbort = v;
    endcase
  endtask

  task automatic pulse(input int kind, input logic [15:0] v);
    @(negedge clk);
    setEv(kind, v);
    @(negedge clk);
    setEv(kind, 16'h0);
  endtask

  function automatic logic [3:0] statAddr(input int kind);
    case (kind)
      0: statAddr = 4'd1;
      1: statAddr = 4'd2;
      2: statAddr = 4'd3;
      3: statAddr = 4'd6;
      default: statAddr = 4'd7;
    endcase
  endfunction

  function automatic int flagBit(input int kind);
    case (kind)
      0: flagBit = 1;
      1: flagBit = 2;
      2: flagBit = 9;
      default: flagBit = 8;
    endcase
  endfunction

  task automatic clearAll();
    wrReg(4'd1, 16'hFFFF); wrReg(4'd2, 16'hFFFF); wrReg(4'd3, 16'hFFFF);
    wrReg(4'd6, 16'hFFFF); wrReg(4'd7, 16'hFFFF); wrReg(4'd8, 16'hFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog: actual 0x%04h expected 0x%04h", 16'h0, 16'h1);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv, rv2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R11 reset state
    rdReg(4'd0, rv); check("R1 mask reset", rv, 16'hFFFF);
    for (int a = 1; a <= 8; a++) begin
      rdReg(4'(a), rv); check("R11 reset status", rv, 16'h0);
    end
    check("R11 irq reset", {15'h0, irq}, 16'h0);

    // R1 read/write
    wrReg(4'd0, 16'h1234); rdReg(4'd0, rv); check("R1 mask rw", rv, 16'h1234);
    check("R1 mask port", maskOut, 16'h1234);

    // R9 several unmasked mailboxes at once, R2
    wrReg(4'd0, 16'h0000);
    pulse(0, 16'h8001);
    rdReg(4'd1, rv); check("R2 multi rx status", rv, 16'h8001);
    check("R9 multi rx flag", irqFlags, 16'h0002);
    clearAll();

    // R7 hw set vs sw clear in the same cycle
    pulse(0, 16'h0020);
    @(negedge clk);
    evRxData = 16'h0010; regWrEn = 1'b1; regAddr = 4'd1; regWrData = 16'h0030;
    @(negedge clk);
    evRxData = '0; regWrEn = 1'b0;
    rdReg(4'd1, rv); check("R7 set beats clear", rv, 16'h0010);
    wrReg(4'd1, 16'h0000); rdReg(4'd1, rv); check("R7 write zero keeps", rv, 16'h0010);

    // R9 event beats flag clear; unused bits stay zero
    @(negedge clk);
    evRxData = 16'h0001; regWrEn = 1'b1; regAddr = 4'd8; regWrData = 16'hFFFF;
    @(negedge clk);
    evRxData = '0; regWrEn = 1'b0;
    check("R9 event beats clear", irqFlags, 16'h0002);
    wrReg(4'd8, 16'h0002); check("R9 w1c", irqFlags, 16'h0000);
    check("R10 line low", {15'h0, irq}, 16'h0);
    clearAll();

    // R8 software set of transmit bits
    wrReg(4'd4, 16'h0003); wrReg(4'd4, 16'h0000);
    rdReg(4'd4, rv); check("R8 w1s, zero no effect", rv, 16'h0003);
    @(negedge clk);
    evTxDone = 16'h0001; regWrEn = 1'b1; regAddr = 4'd4; regWrData = 16'h0001;
    @(negedge clk);
    evTxDone = '0; regWrEn = 1'b0;
    rdReg(4'd4, rv); check("R8 hw clear wins", rv, 16'h0002);
    pulse(4, 16'h0002);
    clearAll();

    // R10 masking later does not clear a set flag
    pulse(2, 16'h0008);
    check("R4 ovr flag", irqFlags, 16'h0200);
    wrReg(4'd0, 16'hFFFF);
    check("R10 no retro clear", irqFlags, 16'h0200);
    check("R10 line high", {15'h0, irq}, 16'h1);
    clearAll();

    // sweep: every mailbox, every event kind, two mask patterns
    for (int p = 0; p < 2; p++) begin
      logic [15:0] msk;
      msk = (p == 0) ? 16'hAAAA : 16'h5555;
      wrReg(4'd0, msk);
      for (int n = 0; n < 16; n++) begin
        for (int k = 0; k < 5; k++) begin
          logic [15:0] b, expFlag;
          b = 16'h1 << n;
          expFlag = msk[n] ? 16'h0 : (16'h1 << flagBit(k));
          if (k >= 3) begin
            wrReg(4'd4, b); wrReg(4'd5, b);
          end
          pulse(k, b);
          rdReg(statAddr(k), rv);
          case (k)
            0: check("R2 rx status", rv, b);
            1: check("R3 remote status", rv, b);
            2: check("R4 unread status", rv, b);
            3: check("R5 txack status", rv, b);
            default: check("R6 abort status", rv, b);
          endcase
          if (k >= 3) begin
            rdReg(4'd4, rv); rdReg(4'd5, rv2);
            if (k == 3) check("R5 pend/cancel cleared", rv | rv2, 16'h0);
            else        check("R6 pend/cancel cleared", rv | rv2, 16'h0);
          end
          case (k)
            0: check("R2 flag gate", irqFlags, expFlag);
            1: check("R3 flag gate", irqFlags, expFlag);
            2: check("R4 flag gate", irqFlags, expFlag);
            3: check("R5 flag gate", irqFlags, expFlag);
            default: check("R6 flag gate", irqFlags, expFlag);
          endcase
          check("R10 line", {15'h0, irq}, {15'h0, !msk[n]});
          wrReg(statAddr(k), b); wrReg(4'd8, 16'hFFFF);
          rdReg(statAddr(k), rv); check("R7 w1c", rv, 16'h0);
          check("R9 cleared", irqFlags, 16'h0);
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule